// File: doc/BRIEF.md
# Sequential Shift-Add Floating-Point Multiplier

This block forms the product of two floating-point operands that an upstream stage has already split into fields. Each operand has a class, a sign, an exponent and a fixed-point mantissa. The result is left unrounded, so that a separate rounding stage can consume it. Numeric products come from a multi-cycle loop over the bits of one mantissa. Each step shifts the accumulator right by one place and adds the other mantissa when the current bit is set. Any bits shifted out are collected into a sticky flag. A multiplier word that is entirely zero costs a single cycle instead of one cycle per bit. Special operands (zero, infinity, NaN) are settled in the cycle that accepts the request.

Before the operands are examined, they are ordered so that the operand with the higher class rank becomes the multiplier side. The cases are then tried in a fixed priority. The exponents are added, and at most one normalising right shift is applied. A requester pulses `start` with valid operand fields. The block answers with a one-cycle `done` pulse, and the result fields stay unchanged until the next accepted request.

The controller has three states. ST_IDLE waits for `start`. From ST_IDLE, a special-case request stays in ST_IDLE and produces its result at once, while a numeric request moves to ST_MUL. ST_MUL performs one bit step or one word skip per cycle and moves to ST_NORM after the last step of the top word. ST_NORM normalises the product, publishes the result and returns to ST_IDLE.

Top module: `fpmul_seq`

## Requirements
- R1: After reset, `done`, `r_cls`, `r_sign`, `r_exp`, `r_mant`, `r_sticky` and `r_invalid` are all zero.
- R2: Class codes are zero=0, number=1, infinity=2, NaN=3. If either operand is NaN, the result takes the class, exponent and mantissa of the NaN operand. When both operands are NaN, operand b supplies these fields. The result sign is the XOR of both signs, and `r_sticky` and `r_invalid` are 0.
- R3: Infinity times zero, in either order, produces a fresh NaN: class 3, sign 0, exponent 0, mantissa with only bit MW-3 set, sticky 0 and `r_invalid` 1.
- R4: Infinity times a number or an infinity produces class 2 with the infinite operand's exponent and mantissa. When both operands are infinite, operand b supplies these fields. The sign is the XOR of both signs, and sticky and invalid are 0.
- R5: Zero times zero or a number produces class 0 with sign equal to the XOR of both signs. Exponent, mantissa, sticky and invalid are all 0.
- R6: For any special-case request, `done` is high in the cycle right after the clock edge that samples `start`.
- R7: A normal mantissa has bit MW-3 set, no bit above it, and its lowest GUARD bits zero. For two numbers with mantissas X and Y, let P = X*Y and L = MW-3. If P is below 2^(2L+1), then `r_mant` = P>>L and `r_sticky` = OR of P[L-1:0]. Otherwise `r_mant` = P>>(L+1) and `r_sticky` = OR of P[L:0].
- R8: For two numbers, `r_exp` equals the sum of the exponents modulo 2^EXP_W, plus 1 when the second branch of R7 applied. In addition, `r_sign` is the XOR of the signs, `r_cls` is 1 and `r_invalid` is 0.
- R9: A numeric request raises `done` C+2 edges after it is accepted, where the accepting edge counts as edge 1. C is the sum of three terms. The lowest word contributes 1 if it is zero, and WORD_W-GUARD otherwise. Each middle word contributes 1 if it is zero, and WORD_W otherwise. The top word contributes WORD_W-2. Throughout this time `done` stays low.
- R10: `done` is a one-cycle pulse. Result fields hold until the next accepted `start`. A `start` raised while a numeric product is in progress is ignored and changes neither the result nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled in ST_IDLE |
| a_cls | input | 2 | Class of operand a |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | EXP_W | Exponent of operand a |
| a_mant | input | MW | Mantissa of operand a |
| b_cls | input | 2 | Class of operand b |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EXP_W | Exponent of operand b |
| b_mant | input | MW | Mantissa of operand b |
| done | output | 1 | Result-valid pulse |
| r_cls | output | 2 | Result class |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result exponent |
| r_mant | output | MW | Unrounded result mantissa |
| r_sticky | output | 1 | OR of all mantissa bits discarded |
| r_invalid | output | 1 | Set for infinity times zero |

## Verification
The assertions rely on operands of class number being normal, as defined in R7: the leading one sits at bit MW-3, nothing is set above it, and the guard bits are zero. Only under that condition does the published numeric mantissa keep its leading one at bit MW-3. The stimulus builds every numeric mantissa by placing the leading one and shifting a free field past the guard bits, so it never leaves that form. It also keeps the exponents small, so that the sums can be checked with plain arithmetic.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fcls_e;

    typedef enum logic [1:0] {
        SP_NONE    = 2'd0,
        SP_PASS_Y  = 2'd1,
        SP_NEW_NAN = 2'd2,
        SP_ZERO    = 2'd3
    } spec_e;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_BIT  = 2'd1,
        ACC_WORD = 2'd2
    } accop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_NORM = 2'd2
    } st_e;

endpackage

// File: rtl/fpmul_order.sv
module fpmul_order
    import fpmul_pkg::*;
#(
    parameter int EXP_W = 16,
    parameter int MW    = 128
) (
    input  logic [1:0]       a_cls,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MW-1:0]    a_mant,
    input  logic [1:0]       b_cls,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MW-1:0]    b_mant,
    output logic             x_sign,
    output logic [EXP_W-1:0] x_exp,
    output logic [MW-1:0]    x_mant,
    output logic [1:0]       y_cls,
    output logic             y_sign,
    output logic [EXP_W-1:0] y_exp,
    output logic [MW-1:0]    y_mant,
    output spec_e            spec
);

    logic       swap;
    logic [1:0] x_cls;

    // The heavier class goes to the multiplier side; ties keep b there.
    always_comb begin
        swap   = (a_cls > b_cls);
        x_cls  = swap ? b_cls  : a_cls;
        x_sign = swap ? b_sign : a_sign;
        x_exp  = swap ? b_exp  : a_exp;
        x_mant = swap ? b_mant : a_mant;
        y_cls  = swap ? a_cls  : b_cls;
        y_sign = swap ? a_sign : b_sign;
        y_exp  = swap ? a_exp  : b_exp;
        y_mant = swap ? a_mant : b_mant;
    end

    always_comb begin
        if (y_cls == CLS_NAN) begin
            spec = SP_PASS_Y;
        end else if (y_cls == CLS_INF) begin
            spec = (x_cls == CLS_ZERO) ? SP_NEW_NAN : SP_PASS_Y;
        end else if (x_cls == CLS_ZERO) begin
            spec = SP_ZERO;
        end else begin
            spec = SP_NONE;
        end
    end

endmodule

// File: rtl/fpmul_accstep.sv
module fpmul_accstep
    import fpmul_pkg::*;
#(
    parameter int MW     = 128,
    parameter int WORD_W = 32
) (
    input  accop_e         op,
    input  logic           add_en,
    input  logic [MW-1:0]  acc,
    input  logic           stk,
    input  logic [MW-1:0]  x_mant,
    output logic [MW-1:0]  acc_n,
    output logic           stk_n
);

    logic [MW-1:0] half;

    always_comb begin
        half  = acc >> 1;
        acc_n = acc;
        stk_n = stk;
        unique case (op)
            ACC_BIT: begin
                stk_n = stk | acc[0];
                acc_n = add_en ? (half + x_mant) : half;
            end
            ACC_WORD: begin
                stk_n = stk | (|acc[WORD_W-1:0]);
                acc_n = acc >> WORD_W;
            end
            default: begin
                acc_n = acc;
                stk_n = stk;
            end
        endcase
    end

endmodule

// File: rtl/fpmul_norm.sv
module fpmul_norm #(
    parameter int MW    = 128,
    parameter int EXP_W = 16
) (
    input  logic [MW-1:0]    acc,
    input  logic             stk,
    input  logic [EXP_W-1:0] exp_sum,
    output logic [MW-1:0]    mant,
    output logic             sticky,
    output logic [EXP_W-1:0] exp_out
);

    localparam int LEAD = MW - 3;

    logic over;

    always_comb begin
        over = acc[LEAD+1];
        if (over) begin
            mant    = acc >> 1;
            sticky  = stk | acc[0];
            exp_out = exp_sum + EXP_W'(1);
        end else begin
            mant    = acc;
            sticky  = stk;
            exp_out = exp_sum;
        end
    end

endmodule

// File: rtl/fpmul_seq.sv
module fpmul_seq
    import fpmul_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int GUARD  = 2,
    parameter int EXP_W  = 16,
    localparam int MW    = WORD_W * NWORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       a_cls,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MW-1:0]    a_mant,
    input  logic [1:0]       b_cls,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MW-1:0]    b_mant,
    output logic             done,
    output logic [1:0]       r_cls,
    output logic             r_sign,
    output logic [EXP_W-1:0] r_exp,
    output logic [MW-1:0]    r_mant,
    output logic             r_sticky,
    output logic             r_invalid
);

    localparam int LEAD    = MW - 3;
    localparam int TOP_BIT = WORD_W - 3;
    localparam int WSEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int BPOS_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    st_e st, st_n;

    logic [WSEL_W-1:0] wsel;
    logic [BPOS_W-1:0] bpos;
    logic [MW-1:0]     acc, xm, ym;
    logic              stk, psign;
    logic [EXP_W-1:0]  esum;

    logic             o_x_sign, o_y_sign;
    logic [EXP_W-1:0] o_x_exp, o_y_exp;
    logic [MW-1:0]    o_x_mant, o_y_mant;
    logic [1:0]       o_y_cls;
    spec_e            spec;

    logic [WORD_W-1:0] y_word;
    logic              at_start, last_word, skip, fin;
    accop_e            acc_op;
    logic [MW-1:0]     acc_n;
    logic              stk_n;
    logic [MW-1:0]     n_mant;
    logic              n_sticky;
    logic [EXP_W-1:0]  n_exp;

    fpmul_order #(.EXP_W(EXP_W), .MW(MW)) u_order (
        .a_cls (a_cls),  .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_cls (b_cls),  .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .x_sign(o_x_sign), .x_exp(o_x_exp), .x_mant(o_x_mant),
        .y_cls (o_y_cls),  .y_sign(o_y_sign), .y_exp(o_y_exp),
        .y_mant(o_y_mant), .spec(spec)
    );

    // Step decode for the current multiplier position.
    always_comb begin
        y_word    = WORD_W'(ym >> (wsel * WORD_W));
        last_word = (wsel == WSEL_W'(NWORDS - 1));
        at_start  = (wsel == '0) ? (bpos == BPOS_W'(GUARD)) : (bpos == '0);
        skip      = at_start && (y_word == '0) && !last_word;
        fin       = last_word && (bpos == BPOS_W'(TOP_BIT));
        if (st != ST_MUL) begin
            acc_op = ACC_HOLD;
        end else if (skip) begin
            acc_op = (wsel == '0) ? ACC_HOLD : ACC_WORD;
        end else begin
            acc_op = ACC_BIT;
        end
    end

    fpmul_accstep #(.MW(MW), .WORD_W(WORD_W)) u_step (
        .op(acc_op), .add_en(y_word[bpos]), .acc(acc), .stk(stk),
        .x_mant(xm), .acc_n(acc_n), .stk_n(stk_n)
    );

    fpmul_norm #(.MW(MW), .EXP_W(EXP_W)) u_norm (
        .acc(acc), .stk(stk), .exp_sum(esum),
        .mant(n_mant), .sticky(n_sticky), .exp_out(n_exp)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Transitions.
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (start && spec == SP_NONE) st_n = ST_MUL;
            ST_MUL:  if (fin) st_n = ST_NORM;
            ST_NORM: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // Datapath and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel <= '0; bpos <= '0; acc <= '0; stk <= 1'b0;
            xm <= '0; ym <= '0; psign <= 1'b0; esum <= '0;
            done <= 1'b0; r_cls <= CLS_ZERO; r_sign <= 1'b0;
            r_exp <= '0; r_mant <= '0; r_sticky <= 1'b0; r_invalid <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        xm    <= o_x_mant;
                        ym    <= o_y_mant;
                        psign <= o_x_sign ^ o_y_sign;
                        esum  <= o_x_exp + o_y_exp;
                        acc   <= '0;
                        stk   <= 1'b0;
                        wsel  <= '0;
                        bpos  <= BPOS_W'(GUARD);
                        if (spec != SP_NONE) begin
                            done      <= 1'b1;
                            r_sticky  <= 1'b0;
                            r_invalid <= (spec == SP_NEW_NAN);
                            unique case (spec)
                                SP_PASS_Y: begin
                                    r_cls  <= o_y_cls;
                                    r_sign <= o_x_sign ^ o_y_sign;
                                    r_exp  <= o_y_exp;
                                    r_mant <= o_y_mant;
                                end
                                SP_NEW_NAN: begin
                                    r_cls  <= CLS_NAN;
                                    r_sign <= 1'b0;
                                    r_exp  <= '0;
                                    r_mant <= MW'(1) << LEAD;
                                end
                                default: begin
                                    r_cls  <= CLS_ZERO;
                                    r_sign <= o_x_sign ^ o_y_sign;
                                    r_exp  <= '0;
                                    r_mant <= '0;
                                end
                            endcase
                        end
                    end
                end
                ST_MUL: begin
                    acc <= acc_n;
                    stk <= stk_n;
                    if (skip || bpos == BPOS_W'(WORD_W - 1)) begin
                        wsel <= wsel + WSEL_W'(1);
                        bpos <= '0;
                    end else begin
                        bpos <= bpos + BPOS_W'(1);
                    end
                end
                ST_NORM: begin
                    done      <= 1'b1;
                    r_cls     <= CLS_NUM;
                    r_sign    <= psign;
                    r_exp     <= n_exp;
                    r_mant    <= n_mant;
                    r_sticky  <= n_sticky;
                    r_invalid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fpmul_seq_chk.sv
module fpmul_seq_chk #(
    parameter int MW    = 128,
    parameter int EXP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       st,
    input logic [1:0]       spec,
    input logic             done,
    input logic [1:0]       r_cls,
    input logic             r_sign,
    input logic [EXP_W-1:0] r_exp,
    input logic [MW-1:0]    r_mant,
    input logic             r_sticky,
    input logic             r_invalid
);

    localparam int LEAD = MW - 3;

    p_newnan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_invalid) |-> (r_cls == 2'd3 && !r_sign && r_mant == (MW'(1) << LEAD)));

    p_zero_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_cls == 2'd0) |-> (r_mant == '0 && r_exp == '0 && !r_sticky && !r_invalid));

    p_special_oneclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0 && start && spec != 2'd0) |=> done);

    p_num_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_cls == 2'd1) |-> (r_mant[LEAD] && (r_mant >> (LEAD + 1)) == '0));

    p_num_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_cls != 2'd3) |-> !r_invalid);

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd1) |-> !done);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({r_cls, r_sign, r_exp, r_mant, r_sticky, r_invalid}));

endmodule

bind fpmul_seq fpmul_seq_chk #(.MW(MW), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .st(st), .spec(spec),
    .done(done), .r_cls(r_cls), .r_sign(r_sign), .r_exp(r_exp),
    .r_mant(r_mant), .r_sticky(r_sticky), .r_invalid(r_invalid)
);

// File: tb/tb_fpmul_seq.sv
`timescale 1ns/1ps
module tb_fpmul_seq;

    localparam int WORD_W = 4;
    localparam int NWORDS = 3;
    localparam int GUARD  = 2;
    localparam int EXP_W  = 8;
    localparam int MW     = WORD_W * NWORDS;
    localparam int LEAD   = MW - 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       a_cls = '0, b_cls = '0;
    logic             a_sign = 1'b0, b_sign = 1'b0;
    logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
    logic [MW-1:0]    a_mant = '0, b_mant = '0;
    logic             done, r_sign, r_sticky, r_invalid;
    logic [1:0]       r_cls;
    logic [EXP_W-1:0] r_exp;
    logic [MW-1:0]    r_mant;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fpmul_seq #(.WORD_W(WORD_W), .NWORDS(NWORDS), .GUARD(GUARD), .EXP_W(EXP_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .done(done), .r_cls(r_cls), .r_sign(r_sign), .r_exp(r_exp),
        .r_mant(r_mant), .r_sticky(r_sticky), .r_invalid(r_invalid)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected result fields.
    logic [1:0]       e_cls;
    logic             e_sign, e_sticky, e_inv;
    logic [EXP_W-1:0] e_exp;
    logic [MW-1:0]    e_mant;
    int               e_lat;

    task automatic model();
        logic [2*MW-1:0] p;
        logic [1:0] xc, yc;
        logic xs, ys;
        logic [EXP_W-1:0] xe, ye;
        logic [MW-1:0] xmt, ymt;
        int c;
        if (a_cls > b_cls) begin
            xc = b_cls; xs = b_sign; xe = b_exp; xmt = b_mant;
            yc = a_cls; ys = a_sign; ye = a_exp; ymt = a_mant;
        end else begin
            xc = a_cls; xs = a_sign; xe = a_exp; xmt = a_mant;
            yc = b_cls; ys = b_sign; ye = b_exp; ymt = b_mant;
        end
        e_sticky = 1'b0; e_inv = 1'b0; e_lat = 1;
        if (yc == 2'd3 || (yc == 2'd2 && xc != 2'd0)) begin
            e_cls = yc; e_sign = xs ^ ys; e_exp = ye; e_mant = ymt;
        end else if (yc == 2'd2) begin
            e_cls = 2'd3; e_sign = 1'b0; e_exp = '0; e_mant = MW'(1) << LEAD; e_inv = 1'b1;
        end else if (xc == 2'd0) begin
            e_cls = 2'd0; e_sign = xs ^ ys; e_exp = '0; e_mant = '0;
        end else begin
            p = (2*MW)'(xmt) * (2*MW)'(ymt);
            e_cls = 2'd1; e_sign = xs ^ ys;
            if (p >= ((2*MW)'(1) << (2*LEAD + 1))) begin
                e_mant = MW'(p >> (LEAD + 1));
                e_sticky = |(p & (((2*MW)'(1) << (LEAD + 1)) - 1));
                e_exp = xe + ye + EXP_W'(1);
            end else begin
                e_mant = MW'(p >> LEAD);
                e_sticky = |(p & (((2*MW)'(1) << LEAD) - 1));
                e_exp = xe + ye;
            end
            c = (ymt[WORD_W-1:0] == '0) ? 1 : (WORD_W - GUARD);
            for (int w = 1; w < NWORDS - 1; w++)
                c += (((ymt >> (w * WORD_W)) & MW'((1 << WORD_W) - 1)) == '0) ? 1 : WORD_W;
            c += WORD_W - 2;
            e_lat = c + 2;
        end
    endtask

    task automatic issue(output int n);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic compare(input int n, input string rq_num);
        if (e_lat == 1) begin
            chk(n == 1, "R6 latency", 64'(n), 64'(1));
        end else begin
            chk(n == e_lat, "R9 latency", 64'(n), 64'(e_lat));
        end
        chk(r_cls == e_cls, {rq_num, " class"}, 64'(r_cls), 64'(e_cls));
        chk(r_sign == e_sign, {rq_num, " sign"}, 64'(r_sign), 64'(e_sign));
        chk(r_exp == e_exp, {rq_num, " exponent"}, 64'(r_exp), 64'(e_exp));
        chk(r_mant == e_mant, {rq_num, " mantissa"}, 64'(r_mant), 64'(e_mant));
        chk(r_sticky == e_sticky, {rq_num, " sticky"}, 64'(r_sticky), 64'(e_sticky));
        chk(r_invalid == e_inv, {rq_num, " invalid"}, 64'(r_invalid), 64'(e_inv));
    endtask

    function automatic string tag_for(input logic [1:0] ca, input logic [1:0] cb);
        if (ca == 2'd3 || cb == 2'd3) return "R2";
        if ((ca == 2'd2 && cb == 2'd0) || (ca == 2'd0 && cb == 2'd2)) return "R3";
        if (ca == 2'd2 || cb == 2'd2) return "R4";
        return "R5";
    endfunction

    initial begin : watchdog
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done", 64'(done), 64'(0));
        chk({r_cls, r_sign, r_exp, r_mant, r_sticky, r_invalid} == '0, "R1 results",
            64'({r_cls, r_sign, r_exp, r_mant, r_sticky, r_invalid}), 64'(0));
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: every class pair and sign pair that is not number times number
        for (int ca = 0; ca < 4; ca++) begin
            for (int cb = 0; cb < 4; cb++) begin
                for (int s = 0; s < 4; s++) begin
                    if (!(ca == 1 && cb == 1)) begin
                        a_cls = 2'(ca); b_cls = 2'(cb);
                        a_sign = s[0]; b_sign = s[1];
                        a_exp = 8'd5; b_exp = 8'hFD;
                        a_mant = 12'h2A4; b_mant = 12'h3C8;
                        model();
                        issue(n);
                        compare(n, tag_for(a_cls, b_cls));
                    end
                end
            end
        end

        // R7 R8 R9: near-exhaustive sweep of normal mantissa pairs
        for (int i = 0; i < 128; i++) begin
            for (int j = 0; j < 128; j++) begin
                if (((i * 7 + j) % 4) == 0) begin
                    a_cls = 2'd1; b_cls = 2'd1;
                    a_sign = i[0]; b_sign = j[1];
                    a_exp = EXP_W'(i % 16) - EXP_W'(8);
                    b_exp = EXP_W'(j % 16) - EXP_W'(8);
                    a_mant = (MW'(1) << LEAD) | (MW'(i) << GUARD);
                    b_mant = (MW'(1) << LEAD) | (MW'(j) << GUARD);
                    model();
                    issue(n);
                    compare(n, "R7 R8");
                end
            end
        end

        // R10: start while busy is ignored; done is a pulse; results hold
        begin
            logic [MW-1:0] keep_m;
            a_cls = 2'd1; b_cls = 2'd1; a_sign = 1'b1; b_sign = 1'b0;
            a_exp = 8'd3; b_exp = 8'd4;
            a_mant = 12'h3FC; b_mant = 12'h3FC;
            model();
            @(negedge clk);
            start = 1'b1;
            @(posedge clk);
            n = 1;
            @(negedge clk);
            start = 1'b0;
            @(posedge clk); n++;
            @(negedge clk);
            a_cls = 2'd2; b_cls = 2'd0; start = 1'b1;
            @(posedge clk); n++;
            @(negedge clk);
            start = 1'b0;
            while (!done && n < 100) begin
                @(posedge clk);
                n++;
                @(negedge clk);
            end
            compare(n, "R10 busy-start");
            keep_m = r_mant;
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(done == 1'b0, "R10 pulse", 64'(done), 64'(0));
            chk(r_mant == keep_m && r_cls == 2'd1, "R10 hold", 64'(r_mant), 64'(keep_m));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule